// File: doc/BRIEF.md
# Integer ALU with Operation Decode and Branch Resolution

This block is the arithmetic core of a small multicycle 32-bit integer processor. It has no clock. It has three parts, and each part works on its own.

- **Datapath.** It takes two 32-bit operands and a 4-bit operation code. The code is a two-bit class field followed by a two-bit sub-operation field. The datapath produces a 32-bit result and a flag that marks an all-zero result.
- **Decoder.** It turns the instruction's major opcode, its three-bit function field and its seven-bit function field into an operation code. A forced-add input overrides the decode, so the control sequencer can do address and program-counter arithmetic.
- **Branch resolver.** It combines the zero flag with two bits of the three-bit function field. From these it decides whether the program counter is written. An unconditional update request also writes the program counter.

In a core, the control sequencer sends the decoded code (directly or through a register) back to the operation input. It then uses the resulting zero flag to resolve all six conditional branches. Each branch is set up so that the zero flag, inverted by the two function bits where needed, gives the taken decision.

Top module: `rvalu_core`

## Requirements
- R1: The operation code is {class[1:0], sub[1:0]}. Class 00 is arithmetic: code 0 adds and code 1 subtracts (opA - opB). Both wrap modulo 2^32.
- R2: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R3: Class 01 is logic: code 4 gives bitwise AND, code 5 gives OR and code 6 gives XOR.
- R4: Code 2 is the signed less-than compare and code 3 is the unsigned less-than compare. Each produces 32'd1 when opA < opB and 32'd0 otherwise.
- R5: Class 10 is shift: code 8 shifts opA left, code 9 shifts it right logically and code 11 shifts it right arithmetically. The shift amount is opB[4:0], and opB[31:5] are ignored.
- R6: The unused codes 7, 10, 12, 13, 14 and 15 give a result of 0, so `zero` is 1.
- R7: While `forceAdd` is 1, `decodedOp` is 0 (add), whatever the instruction fields are.
- R8: For opcodes 0110011 (register form) and 0010011 (immediate form), the function field maps as follows:
  - 000 gives code 1 only for the register form with funct7 = 0100000, and code 0 otherwise.
  - 001 gives 8, 010 gives 2, 011 gives 3, 100 gives 6, 110 gives 5 and 111 gives 4.
  - 101 gives 11 when funct7 = 0100000, and 9 otherwise.
- R9: For opcode 1100011, funct3 000 and 001 give code 1, funct3 100 and 101 give code 2, funct3 110 and 111 give code 3, and 010 and 011 give code 0. Any opcode other than the three named ones gives code 0.
- R10: `pcWrite` = ((zero XOR funct3[0] XOR funct3[2]) AND branchEn) OR pcUpdate. With the branch codes of R9, this takes the branch on equal, not equal, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand; its low 5 bits are the shift amount |
| aluOpIn | input | 4 | Operation code applied to the datapath |
| opcode | input | 7 | Major opcode of the instruction |
| funct3 | input | 3 | Three-bit function field |
| funct7 | input | 7 | Seven-bit function field |
| forceAdd | input | 1 | Forces the decoded code to add |
| branchEn | input | 1 | The current step evaluates a conditional branch |
| pcUpdate | input | 1 | Unconditional program-counter write request |
| result | output | 32 | Datapath result |
| zero | output | 1 | High when result is all zeros |
| decodedOp | output | 4 | Operation code decoded from the instruction fields |
| pcWrite | output | 1 | Program-counter write enable |

## Verification
The hardest cases are the branch decisions. A correct decision needs the decoded compare code fed back into the datapath, the right operand relation, and the function bits held at the same time. The bench plays the role of the sequencer: it chooses the operation code from its own decode table for each of the six branch conditions. It then drives operand pairs that are equal, ordered one way and ordered the other, including pairs where the signed and unsigned orders disagree and where the signed subtraction overflows. The unused operation codes cannot be reached through the decoder, so the bench applies them directly on the operation input.

// File: rtl/rvalu_pkg.sv
package rvalu_pkg;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'b00,
    CLS_LOGIC = 2'b01,
    CLS_SHIFT = 2'b10,
    CLS_RSVD  = 2'b11
  } opClass_e;

  // Strobe bundle from decode/control to the datapath.
  typedef struct packed {
    opClass_e   cls;
    logic [1:0] sub;
  } aluOp_t;

  localparam logic [1:0] SUB_ADD  = 2'b00;
  localparam logic [1:0] SUB_SUB  = 2'b01;
  localparam logic [1:0] SUB_SLT  = 2'b10;
  localparam logic [1:0] SUB_SLTU = 2'b11;
  localparam logic [1:0] SUB_AND  = 2'b00;
  localparam logic [1:0] SUB_OR   = 2'b01;
  localparam logic [1:0] SUB_XOR  = 2'b10;
  localparam logic [1:0] SUB_SLL  = 2'b00;
  localparam logic [1:0] SUB_SRL  = 2'b01;
  localparam logic [1:0] SUB_SRA  = 2'b11;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] F7_ALT     = 7'b0100000;

  function automatic aluOp_t mkOp(opClass_e c, logic [1:0] s);
    aluOp_t o;
    o.cls = c;
    o.sub = s;
    return o;
  endfunction

endpackage

// File: rtl/rvalu_decode.sv
module rvalu_decode
  import rvalu_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  input  logic       forceAdd,
  output aluOp_t     decOp
);

  logic isRegForm;
  logic isAluForm;
  logic altF7;

  assign isRegForm = (opcode == OPC_REG);
  assign isAluForm = isRegForm || (opcode == OPC_IMM);
  assign altF7     = (funct7 == F7_ALT);

  always_comb begin
    decOp = mkOp(CLS_ARITH, SUB_ADD);
    if (forceAdd) begin
      decOp = mkOp(CLS_ARITH, SUB_ADD);
    end else if (isAluForm) begin
      case (funct3)
        3'b000:  decOp = (isRegForm && altF7) ? mkOp(CLS_ARITH, SUB_SUB)
                                              : mkOp(CLS_ARITH, SUB_ADD);
        3'b001:  decOp = mkOp(CLS_SHIFT, SUB_SLL);
        3'b010:  decOp = mkOp(CLS_ARITH, SUB_SLT);
        3'b011:  decOp = mkOp(CLS_ARITH, SUB_SLTU);
        3'b100:  decOp = mkOp(CLS_LOGIC, SUB_XOR);
        3'b101:  decOp = altF7 ? mkOp(CLS_SHIFT, SUB_SRA)
                               : mkOp(CLS_SHIFT, SUB_SRL);
        3'b110:  decOp = mkOp(CLS_LOGIC, SUB_OR);
        default: decOp = mkOp(CLS_LOGIC, SUB_AND);
      endcase
    end else if (opcode == OPC_BRANCH) begin
      case (funct3)
        3'b000, 3'b001: decOp = mkOp(CLS_ARITH, SUB_SUB);
        3'b100, 3'b101: decOp = mkOp(CLS_ARITH, SUB_SLT);
        3'b110, 3'b111: decOp = mkOp(CLS_ARITH, SUB_SLTU);
        default:        decOp = mkOp(CLS_ARITH, SUB_ADD);
      endcase
    end
  end

endmodule

// File: rtl/rvalu_branch.sv
module rvalu_branch (
  input  logic       zero,
  input  logic [2:0] funct3,
  input  logic       branchEn,
  input  logic       pcUpdate,
  output logic       pcWrite
);

  // funct3[0] flips the sense (eq/ne, lt/ge); funct3[2] marks compares
  // whose true outcome is a nonzero result.
  logic condTrue;

  assign condTrue = zero ^ funct3[0] ^ funct3[2];
  assign pcWrite  = (condTrue & branchEn) | pcUpdate;

endmodule

// File: rtl/rvalu_shifter.sv
module rvalu_shifter #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic            dirLeft,
  input  logic            arith,
  output logic [XLEN-1:0] dout
);

  function automatic logic [XLEN-1:0] rev(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  logic            fill;
  logic [XLEN-1:0] stage [0:SHW];

  // A left shift is a right shift of the bit-reversed word.
  assign fill     = arith & ~dirLeft & din[XLEN-1];
  assign stage[0] = dirLeft ? rev(din) : din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][XLEN-1:STEP]}
                               : stage[s];
  end

  assign dout = dirLeft ? rev(stage[SHW]) : stage[SHW];

endmodule

// File: rtl/rvalu_datapath.sv
module rvalu_datapath
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluOp_t          op,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  logic            subMode;
  logic [XLEN:0]   sum;
  logic            ltUnsigned;
  logic            ltSigned;
  logic [XLEN-1:0] shOut;

  // One shared adder: subtract, and both compares, use a + ~b + 1.
  assign subMode = (op.cls == CLS_ARITH) && (op.sub != SUB_ADD);
  assign sum     = {1'b0, opA} + {1'b0, opB ^ {XLEN{subMode}}}
                 + {{XLEN{1'b0}}, subMode};
  assign ltUnsigned = ~sum[XLEN];
  assign ltSigned   = (opA[XLEN-1] ^ opB[XLEN-1]) ? opA[XLEN-1] : sum[XLEN-1];

  rvalu_shifter #(.XLEN(XLEN)) u_shift (
    .din    (opA),
    .amt    (opB[SHW-1:0]),
    .dirLeft(op.sub == SUB_SLL),
    .arith  (op.sub == SUB_SRA),
    .dout   (shOut)
  );

  always_comb begin
    result = '0;
    case (op.cls)
      CLS_ARITH: begin
        case (op.sub)
          SUB_SLT:  result = {{(XLEN-1){1'b0}}, ltSigned};
          SUB_SLTU: result = {{(XLEN-1){1'b0}}, ltUnsigned};
          default:  result = sum[XLEN-1:0];
        endcase
      end
      CLS_LOGIC: begin
        case (op.sub)
          SUB_AND: result = opA & opB;
          SUB_OR:  result = opA | opB;
          SUB_XOR: result = opA ^ opB;
          default: result = '0;
        endcase
      end
      CLS_SHIFT: begin
        if (op.sub != 2'b10) result = shOut;
      end
      default: result = '0;
    endcase
  end

  assign zero = ~|result;

endmodule

// File: rtl/rvalu_core.sv
module rvalu_core
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [3:0]      aluOpIn,
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic [6:0]      funct7,
  input  logic            forceAdd,
  input  logic            branchEn,
  input  logic            pcUpdate,
  output logic [XLEN-1:0] result,
  output logic            zero,
  output logic [3:0]      decodedOp,
  output logic            pcWrite
);

  aluOp_t decOp;
  aluOp_t exeOp;

  assign exeOp     = aluOp_t'(aluOpIn);
  assign decodedOp = decOp;

  rvalu_decode u_dec (
    .opcode  (opcode),
    .funct3  (funct3),
    .funct7  (funct7),
    .forceAdd(forceAdd),
    .decOp   (decOp)
  );

  rvalu_datapath #(.XLEN(XLEN)) u_dp (
    .opA   (opA),
    .opB   (opB),
    .op    (exeOp),
    .result(result),
    .zero  (zero)
  );

  rvalu_branch u_br (
    .zero    (zero),
    .funct3  (funct3),
    .branchEn(branchEn),
    .pcUpdate(pcUpdate),
    .pcWrite (pcWrite)
  );

endmodule

// File: rtl/rvalu_core_chk.sv
module rvalu_core_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] opA,
  input logic [XLEN-1:0] opB,
  input logic [3:0]      aluOpIn,
  input logic            forceAdd,
  input logic            branchEn,
  input logic            pcUpdate,
  input logic [XLEN-1:0] result,
  input logic            zero,
  input logic [3:0]      decodedOp,
  input logic            pcWrite
);

  logic unusedCode;
  assign unusedCode = (aluOpIn == 4'd7) || (aluOpIn == 4'd10) || (aluOpIn >= 4'd12);

  always_comb begin
    if (forceAdd) a_r7_force_add: assert (decodedOp == 4'd0);
    if (pcUpdate) a_r10_pc_update: assert (pcWrite);
    if (!pcUpdate && !branchEn) a_r10_no_request: assert (!pcWrite);
    if (aluOpIn == 4'd2 || aluOpIn == 4'd3)
      a_r4_compare_bool: assert (result[XLEN-1:1] == '0);
    if (unusedCode) a_r6_unused_zero: assert (result == '0 && zero);
    if (aluOpIn == 4'd1 && opA == opB) a_r2_sub_self_zero: assert (zero);
    if (aluOpIn == 4'd4)
      a_r3_and_subset: assert (((result & ~opA) == '0) && ((result & ~opB) == '0));
  end

endmodule

bind rvalu_core rvalu_core_chk #(.XLEN(XLEN)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .aluOpIn  (aluOpIn),
  .forceAdd (forceAdd),
  .branchEn (branchEn),
  .pcUpdate (pcUpdate),
  .result   (result),
  .zero     (zero),
  .decodedOp(decodedOp),
  .pcWrite  (pcWrite)
);

// File: tb/rvalu_core_tb.sv
`timescale 1ns/1ps
module rvalu_core_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] opA = '0, opB = '0;
  logic [3:0]  aluOpIn = '0;
  logic [6:0]  opcode = '0, funct7 = '0;
  logic [2:0]  funct3 = '0;
  logic        forceAdd = 1'b0, branchEn = 1'b0, pcUpdate = 1'b0;
  logic [31:0] result;
  logic        zero;
  logic [3:0]  decodedOp;
  logic        pcWrite;

  rvalu_core u_dut (
    .opA(opA), .opB(opB), .aluOpIn(aluOpIn), .opcode(opcode), .funct3(funct3),
    .funct7(funct7), .forceAdd(forceAdd), .branchEn(branchEn), .pcUpdate(pcUpdate),
    .result(result), .zero(zero), .decodedOp(decodedOp), .pcWrite(pcWrite)
  );

  // kind: 0 result, 1 zero, 2 decodedOp, 3 pcWrite
  typedef struct { string req; int kind; logic [31:0] exp; } item_t;
  item_t sbq[$];
  item_t cur;
  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  function automatic logic [31:0] refAlu(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd3:  return (a < b) ? 32'd1 : 32'd0;
      4'd4:  return a & b;
      4'd5:  return a | b;
      4'd6:  return a ^ b;
      4'd8:  return a << b[4:0];
      4'd9:  return a >> b[4:0];
      4'd11: return $signed(a) >>> b[4:0];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [3:0] refDec(logic [6:0] opc, logic [2:0] f3, logic [6:0] f7, logic fa);
    if (fa) return 4'd0;
    if (opc == 7'b0110011 || opc == 7'b0010011) begin
      if (f3 == 3'b000) return (opc == 7'b0110011 && f7 == 7'b0100000) ? 4'd1 : 4'd0;
      if (f3 == 3'b001) return 4'd8;
      if (f3 == 3'b010) return 4'd2;
      if (f3 == 3'b011) return 4'd3;
      if (f3 == 3'b100) return 4'd6;
      if (f3 == 3'b101) return (f7 == 7'b0100000) ? 4'd11 : 4'd9;
      if (f3 == 3'b110) return 4'd5;
      return 4'd4;
    end
    if (opc == 7'b1100011) begin
      if (f3 == 3'b000 || f3 == 3'b001) return 4'd1;
      if (f3 == 3'b100 || f3 == 3'b101) return 4'd2;
      if (f3 == 3'b110 || f3 == 3'b111) return 4'd3;
    end
    return 4'd0;
  endfunction

  function automatic logic branchTaken(logic [2:0] f3, logic [31:0] a, logic [31:0] b);
    case (f3)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      default: return a >= b;
    endcase
  endfunction

  task automatic push(string req, int kind, logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sbq.push_back(it);
  endtask

  function automatic string aluReq(logic [3:0] op);
    case (op)
      4'd0, 4'd1:       return "R1";
      4'd2, 4'd3:       return "R4";
      4'd4, 4'd5, 4'd6: return "R3";
      4'd8, 4'd9, 4'd11:return "R5";
      default:          return "R6";
    endcase
  endfunction

  task automatic applyAlu(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    logic [31:0] e;
    @(posedge clk); #1;
    opA = a; opB = b; aluOpIn = op;
    branchEn = 1'b0; pcUpdate = 1'b0; forceAdd = 1'b0;
    e = refAlu(a, b, op);
    push(aluReq(op), 0, e);
    push("R2", 1, {31'd0, e == 32'd0});
  endtask

  task automatic applyDec(logic [6:0] opc, logic [2:0] f3, logic [6:0] f7, logic fa, string req);
    @(posedge clk); #1;
    opcode = opc; funct3 = f3; funct7 = f7; forceAdd = fa;
    branchEn = 1'b0; pcUpdate = 1'b0;
    push(req, 2, {28'd0, refDec(opc, f3, f7, fa)});
  endtask

  task automatic applyBranch(logic [2:0] f3, logic [31:0] a, logic [31:0] b, logic be, logic pu);
    @(posedge clk); #1;
    opcode = 7'b1100011; funct3 = f3; funct7 = 7'd0; forceAdd = 1'b0;
    aluOpIn = refDec(7'b1100011, f3, 7'd0, 1'b0);
    opA = a; opB = b; branchEn = be; pcUpdate = pu;
    push("R10", 3, {31'd0, (be & branchTaken(f3, a, b)) | pu});
  endtask

  // Monitor: compare at the falling edge, away from input changes.
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      logic [31:0] act;
      cur = sbq.pop_front();
      case (cur.kind)
        0:       act = result;
        1:       act = {31'd0, zero};
        2:       act = {28'd0, decodedOp};
        default: act = {31'd0, pcWrite};
      endcase
      total++;
      if (act !== cur.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", cur.req, cur.kind, act, cur.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [31:0] corners [0:7];
  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h0000_0001; corners[5] = 32'h0000_001F;
    corners[6] = 32'hFFFF_FFE1; corners[7] = 32'h1234_5678;

    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset / idle state: all inputs low.
    @(posedge clk); #1;
    push("R1", 0, 32'd0);
    push("R2", 1, 32'd1);
    push("R7", 2, 32'd0);
    push("R10", 3, 32'd0);

    // Corner operands for every code (R1 R3 R4 R5 R6).
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          applyAlu(corners[i], corners[j], 4'(op));

    // Random operands for every code.
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 150; k++)
        applyAlu($urandom(), $urandom(), 4'(op));

    // R5: upper bits of opB ignored, amounts 0 and 31.
    applyAlu(32'h8000_0001, 32'hFFFF_FFE0, 4'd9);
    applyAlu(32'h8000_0001, 32'h0000_003F, 4'd11);
    applyAlu(32'h8000_0001, 32'hABCD_EF1F, 4'd8);

    // R8: register and immediate forms, both funct7 values.
    for (int f = 0; f < 8; f++) begin
      applyDec(7'b0110011, 3'(f), 7'b0000000, 1'b0, "R8");
      applyDec(7'b0110011, 3'(f), 7'b0100000, 1'b0, "R8");
      applyDec(7'b0010011, 3'(f), 7'b0000000, 1'b0, "R8");
      applyDec(7'b0010011, 3'(f), 7'b0100000, 1'b0, "R8");
      applyDec(7'b1100011, 3'(f), 7'b0000000, 1'b0, "R9");
      applyDec(7'b0000011, 3'(f), 7'b0100000, 1'b0, "R9");
      applyDec(7'b0110011, 3'(f), 7'b0100000, 1'b1, "R7");
      applyDec(7'b1100011, 3'(f), 7'b0000000, 1'b1, "R7");
    end

    // R10: all six branches against several operand relations.
    for (int f = 0; f < 8; f++) begin
      if (f == 2 || f == 3) continue;
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          applyBranch(3'(f), corners[i], corners[j], 1'b1, 1'b0);
      applyBranch(3'(f), 32'd5, 32'd5, 1'b0, 1'b0);
      applyBranch(3'(f), 32'd5, 32'd9, 1'b0, 1'b0);
      applyBranch(3'(f), 32'd5, 32'd9, 1'b0, 1'b1);
      applyBranch(3'(f), 32'd5, 32'd5, 1'b1, 1'b1);
    end

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule